// File: doc/BRIEF.md
# Segment Map Builder

This block builds the table that maps logical segments to physical segments in a multi-bank flash store. An upstream reader walks the store with the bank as the outer loop and the physical segment as the inner loop. For every segment it presents the 16-byte spare record found behind the first sector, together with the record's bank and physical segment number. The walk is done twice. The block decodes each record's type byte and its logical segment number. It then writes the pair {bank, physical segment} into an on-chip table indexed by that logical number.

Two record kinds place data. Kind 0x17 is accepted only in the base pass. Kind 0x13 is accepted only in the override pass, so it replaces whatever the base pass left at the same index. Records of kind 0x15 are cache segments. They are counted in the base pass up to a limit of eight, and any further one raises a sticky overflow flag. Once the second walk ends, the block raises `done` and serves one-cycle lookups.

The control state machine has six states:

- `ST_IDLE` waits after reset.
- `ST_CLEAR` fills every entry with the all-ones empty code, one entry per cycle.
- `ST_PASS_BASE` and `ST_PASS_OVR` accept records.
- `ST_COMMIT` writes the pending record and steps the walk counter.
- `ST_READY` holds the finished table.

The transitions are:

- IDLE or READY to CLEAR on `start`.
- CLEAR to PASS_BASE after the last entry is cleared.
- PASS_x to COMMIT when a record is accepted.
- COMMIT back to the same pass while the walk is not at its last segment.
- COMMIT from PASS_BASE to PASS_OVR at the end of the walk.
- COMMIT from PASS_OVR to READY at the end of the walk.

Top module: `seg_map_builder`

## Requirements
- R1: After reset `done`, `rec_ready`, `lk_ack` and `lk_hit` are 0, the cache count is 0 and the overflow flag is 0; a lookup request before `done` returns `lk_ack` = 0.
- R2: A `start` seen in IDLE or READY holds `rec_ready` low for exactly TBL_DEPTH cycles while every entry is set to the empty code (all ones), so no entry written by an earlier build survives.
- R3: In `rec_spare` byte n occupies bits [8n+7:8n]; byte 4 is the record type and the logical index is byte 6 × 256 + byte 7; all other bytes have no effect.
- R4: In the base pass a type 0x17 record with an in-range index stores {rec_bank, rec_pseg} at that index; records of any other type leave the table unchanged.
- R5: In the override pass a type 0x13 record with an in-range index overwrites the entry at that index; type 0x17 records are ignored in this pass, and type 0x13 records are ignored in the base pass.
- R6: A record whose logical index is not below TBL_DEPTH changes no entry.
- R7: Records arrive bank-major, with physical segment as the inner loop; each pass ends after num_banks × SEGS_PER_BANK records.
- R8: After every accepted record `rec_ready` is low for one cycle while the entry is written.
- R9: `done` rises one cycle after the final record of the override pass is accepted and stays high until the next `start`; `rec_ready` is low while `done` is high.
- R10: With `done` high, a lookup request yields `lk_ack` one cycle later. `lk_hit` is 1 only for an in-range index holding a non-empty entry, and then `lk_bank`/`lk_pseg` carry that entry.
- R11: Type 0x15 records are counted only in the base pass. The count saturates at MAX_CACHE, and a record beyond that sets `cache_overflow`, which stays set until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a build (clear, then two passes) |
| num_banks | input | BANKC_W | Number of populated banks, 1..NUM_BANKS_MAX, sampled at start |
| rec_valid | input | 1 | Spare record offered |
| rec_ready | output | 1 | Block accepts a record this cycle |
| rec_bank | input | BANK_W | Bank the record was read from |
| rec_pseg | input | PSEG_W | Physical segment the record was read from |
| rec_spare | input | 128 | 16 spare bytes, byte n at bits [8n+7:8n] |
| done | output | 1 | Table complete, lookups served |
| cache_segs | output | CNT_W | Cache segments counted in the base pass |
| cache_overflow | output | 1 | More than MAX_CACHE cache segments seen |
| lk_req | input | 1 | Lookup request |
| lk_idx | input | 16 | Logical segment to look up |
| lk_ack | output | 1 | Lookup answer valid |
| lk_hit | output | 1 | Entry present |
| lk_bank | output | BANK_W | Bank of the entry |
| lk_pseg | output | PSEG_W | Physical segment of the entry |

## Verification
The assertions check on every cycle:

- the one-cycle back-pressure after each accepted record;
- that record tags follow the bank-major walk;
- the saturation of the cache count and the stickiness of the overflow flag;
- the one-cycle lookup latency;
- that `rec_ready` never overlaps `done`.

Only the bench scenarios can show that the table contents are right. Two builds with different bank counts are swept over every index and compared with an arithmetic model. That sweep covers override collisions, out-of-range indices including a non-zero high byte, and the clearing of a previous build.

// File: rtl/seg_map_pkg.sv
package seg_map_pkg;
    localparam logic [7:0] KIND_MAIN  = 8'h17;
    localparam logic [7:0] KIND_OVR   = 8'h13;
    localparam logic [7:0] KIND_CACHE = 8'h15;
    localparam int         POS_KIND   = 4;
    localparam int         POS_LHI    = 6;
    localparam int         POS_LLO    = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_PASS_BASE,
        ST_PASS_OVR,
        ST_COMMIT,
        ST_READY
    } scan_state_t;
endpackage

// File: rtl/seg_map_table.sv
module seg_map_table #(
    parameter int DEPTH = 20,
    parameter int IDX_W = 5,
    parameter int ENT_W = 5
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ENT_W-1:0] wr_ent,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ENT_W-1:0] rd_ent
);
    logic [ENT_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_ent;
        end
        rd_ent <= mem[rd_idx];
    end
endmodule

// File: rtl/seg_rec_decode.sv
module seg_rec_decode
    import seg_map_pkg::*;
#(
    parameter int TBL_DEPTH = 20
) (
    input  logic [127:0] spare,
    input  logic         ovr_pass,
    output logic [15:0]  lidx,
    output logic         map_hit,
    output logic         cache_hit
);
    logic [7:0] kind;
    logic       in_range;

    always_comb begin
        kind      = spare[8*POS_KIND +: 8];
        lidx      = {spare[8*POS_LHI +: 8], spare[8*POS_LLO +: 8]};
        in_range  = (lidx < 16'(TBL_DEPTH));
        map_hit   = in_range && (ovr_pass ? (kind == KIND_OVR) : (kind == KIND_MAIN));
        cache_hit = !ovr_pass && (kind == KIND_CACHE);
    end
endmodule

// File: rtl/seg_scan_walk.sv
module seg_scan_walk #(
    parameter int NUM_BANKS_MAX = 4,
    parameter int SEGS_PER_BANK = 6,
    parameter int BANK_W        = 2,
    parameter int BANKC_W       = 3,
    parameter int PSEG_W        = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               step,
    input  logic [BANKC_W-1:0] num_banks,
    output logic [BANK_W-1:0]  cur_bank,
    output logic [PSEG_W-1:0]  cur_seg,
    output logic               at_last
);
    logic [BANKC_W-1:0] nb_q;
    logic               seg_end;

    always_comb begin
        seg_end = (cur_seg == PSEG_W'(SEGS_PER_BANK - 1));
        at_last = seg_end && (BANKC_W'(cur_bank) == nb_q - BANKC_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nb_q     <= '0;
            cur_bank <= '0;
            cur_seg  <= '0;
        end else if (restart) begin
            nb_q     <= num_banks;
            cur_bank <= '0;
            cur_seg  <= '0;
        end else if (step) begin
            if (at_last) begin
                cur_bank <= '0;
                cur_seg  <= '0;
            end else if (seg_end) begin
                cur_bank <= cur_bank + BANK_W'(1);
                cur_seg  <= '0;
            end else begin
                cur_seg  <= cur_seg + PSEG_W'(1);
            end
        end
    end

    AST_BANK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (nb_q != '0) |-> (BANKC_W'(cur_bank) < nb_q)); // R7
endmodule

// File: rtl/seg_map_builder.sv
module seg_map_builder
    import seg_map_pkg::*;
#(
    parameter int NUM_BANKS_MAX = 4,
    parameter int SEGS_PER_BANK = 6,
    parameter int TBL_DEPTH     = 20,
    parameter int MAX_CACHE     = 8,
    localparam int BANK_W  = (NUM_BANKS_MAX > 1) ? $clog2(NUM_BANKS_MAX) : 1,
    localparam int BANKC_W = $clog2(NUM_BANKS_MAX + 1),
    localparam int PSEG_W  = $clog2(SEGS_PER_BANK + 1),
    localparam int CNT_W   = $clog2(MAX_CACHE + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [BANKC_W-1:0] num_banks,
    input  logic               rec_valid,
    output logic               rec_ready,
    input  logic [BANK_W-1:0]  rec_bank,
    input  logic [PSEG_W-1:0]  rec_pseg,
    input  logic [127:0]       rec_spare,
    output logic               done,
    output logic [CNT_W-1:0]   cache_segs,
    output logic               cache_overflow,
    input  logic               lk_req,
    input  logic [15:0]        lk_idx,
    output logic               lk_ack,
    output logic               lk_hit,
    output logic [BANK_W-1:0]  lk_bank,
    output logic [PSEG_W-1:0]  lk_pseg
);
    localparam int IDX_W = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1;
    localparam int ENT_W = BANK_W + PSEG_W;
    localparam logic [ENT_W-1:0] EMPTY = '1;

    scan_state_t      st, nxt;
    logic [IDX_W-1:0] clr_idx;
    logic             in_ovr;
    logic             pend_map;
    logic [IDX_W-1:0] pend_idx;
    logic [ENT_W-1:0] pend_ent;
    logic             lk_inr;
    logic             start_acc, hs;
    logic [15:0]      dec_lidx;
    logic             dec_map, dec_cache;
    logic [BANK_W-1:0] walk_bank;
    logic [PSEG_W-1:0] walk_seg;
    logic             walk_last;
    logic             tbl_we;
    logic [IDX_W-1:0] tbl_widx, tbl_ridx;
    logic [ENT_W-1:0] tbl_went, tbl_rent;

    seg_rec_decode #(.TBL_DEPTH(TBL_DEPTH)) u_dec (
        .spare(rec_spare), .ovr_pass(st == ST_PASS_OVR),
        .lidx(dec_lidx), .map_hit(dec_map), .cache_hit(dec_cache)
    );

    seg_scan_walk #(
        .NUM_BANKS_MAX(NUM_BANKS_MAX), .SEGS_PER_BANK(SEGS_PER_BANK),
        .BANK_W(BANK_W), .BANKC_W(BANKC_W), .PSEG_W(PSEG_W)
    ) u_walk (
        .clk(clk), .rst_n(rst_n), .restart(start_acc), .step(st == ST_COMMIT),
        .num_banks(num_banks), .cur_bank(walk_bank), .cur_seg(walk_seg),
        .at_last(walk_last)
    );

    seg_map_table #(.DEPTH(TBL_DEPTH), .IDX_W(IDX_W), .ENT_W(ENT_W)) u_tbl (
        .clk(clk), .wr_en(tbl_we), .wr_idx(tbl_widx), .wr_ent(tbl_went),
        .rd_idx(tbl_ridx), .rd_ent(tbl_rent)
    );

    // next state
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE, ST_READY: if (start) nxt = ST_CLEAR;
            ST_CLEAR:          if (clr_idx == IDX_W'(TBL_DEPTH - 1)) nxt = ST_PASS_BASE;
            ST_PASS_BASE,
            ST_PASS_OVR:       if (rec_valid) nxt = ST_COMMIT;
            ST_COMMIT: begin
                if (walk_last) nxt = in_ovr ? ST_READY : ST_PASS_OVR;
                else           nxt = in_ovr ? ST_PASS_OVR : ST_PASS_BASE;
            end
            default:           nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // outputs and table port control
    always_comb begin
        rec_ready = (st == ST_PASS_BASE) || (st == ST_PASS_OVR);
        done      = (st == ST_READY);
        start_acc = start && ((st == ST_IDLE) || (st == ST_READY));
        hs        = rec_valid && rec_ready;
        tbl_we    = (st == ST_CLEAR) || ((st == ST_COMMIT) && pend_map);
        tbl_widx  = (st == ST_CLEAR) ? clr_idx : pend_idx;
        tbl_went  = (st == ST_CLEAR) ? EMPTY : pend_ent;
        tbl_ridx  = (lk_idx < 16'(TBL_DEPTH)) ? lk_idx[IDX_W-1:0] : '0;
        lk_hit    = lk_ack && lk_inr && (tbl_rent != EMPTY);
        lk_bank   = tbl_rent[ENT_W-1 -: BANK_W];
        lk_pseg   = tbl_rent[PSEG_W-1:0];
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_idx        <= '0;
            in_ovr         <= 1'b0;
            pend_map       <= 1'b0;
            pend_idx       <= '0;
            pend_ent       <= '0;
            cache_segs     <= '0;
            cache_overflow <= 1'b0;
            lk_ack         <= 1'b0;
            lk_inr         <= 1'b0;
        end else begin
            lk_ack <= lk_req && done;
            lk_inr <= (lk_idx < 16'(TBL_DEPTH));
            if (start_acc) begin
                clr_idx        <= '0;
                in_ovr         <= 1'b0;
                cache_segs     <= '0;
                cache_overflow <= 1'b0;
            end
            if (st == ST_CLEAR) clr_idx <= clr_idx + IDX_W'(1);
            if (hs) begin
                pend_map <= dec_map;
                pend_idx <= dec_lidx[IDX_W-1:0];
                pend_ent <= {rec_bank, rec_pseg};
                if (dec_cache) begin
                    if (cache_segs == CNT_W'(MAX_CACHE)) cache_overflow <= 1'b1;
                    else                                 cache_segs <= cache_segs + CNT_W'(1);
                end
            end
            if ((st == ST_COMMIT) && walk_last) in_ovr <= 1'b1;
        end
    end

    AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_ready) |=> !rec_ready); // R8
    AST_SCAN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_ready) |-> (rec_bank == walk_bank && rec_pseg == walk_seg)); // R7
    AST_CACHE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cache_segs <= CNT_W'(MAX_CACHE)); // R11
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_overflow && !start) |=> cache_overflow); // R11
    AST_LK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && done) |=> lk_ack); // R10
    AST_HIT_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_ack); // R10
    AST_DONE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rec_ready); // R9
endmodule

// File: tb/tb_seg_map_builder.sv
module tb_seg_map_builder;
    localparam int CLK_P   = 10;
    localparam int NBMAX   = 4;
    localparam int SEGS    = 6;
    localparam int DEPTH   = 20;
    localparam int MAXC    = 8;
    localparam int BANK_W  = 2;
    localparam int BANKC_W = 3;
    localparam int PSEG_W  = 3;
    localparam int CNT_W   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [BANKC_W-1:0] num_banks = '0;
    logic rec_valid = 1'b0;
    logic rec_ready;
    logic [BANK_W-1:0] rec_bank = '0;
    logic [PSEG_W-1:0] rec_pseg = '0;
    logic [127:0] rec_spare = '0;
    logic done;
    logic [CNT_W-1:0] cache_segs;
    logic cache_overflow;
    logic lk_req = 1'b0;
    logic [15:0] lk_idx = '0;
    logic lk_ack, lk_hit;
    logic [BANK_W-1:0] lk_bank;
    logic [PSEG_W-1:0] lk_pseg;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    int mdl_bank [DEPTH];
    int mdl_pseg [DEPTH];
    bit mdl_v    [DEPTH];

    always #(CLK_P/2) clk = ~clk;

    seg_map_builder #(
        .NUM_BANKS_MAX(NBMAX), .SEGS_PER_BANK(SEGS),
        .TBL_DEPTH(DEPTH), .MAX_CACHE(MAXC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .num_banks(num_banks),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_bank(rec_bank),
        .rec_pseg(rec_pseg), .rec_spare(rec_spare), .done(done),
        .cache_segs(cache_segs), .cache_overflow(cache_overflow),
        .lk_req(lk_req), .lk_idx(lk_idx), .lk_ack(lk_ack), .lk_hit(lk_hit),
        .lk_bank(lk_bank), .lk_pseg(lk_pseg)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] gen_kind(input int run, input int k);
        if (run == 0) begin
            case (k % 4)
                0: return 8'h17;
                1: return 8'h13;
                2: return 8'h15;
                default: return 8'h22;
            endcase
        end
        if (k < 10) return 8'h15;
        return (k % 2 == 0) ? 8'h17 : 8'h13;
    endfunction

    function automatic int gen_lidx(input int run, input int k);
        int j;
        if (run == 0) return (k * 7) % 24;
        if (k < 10) return k;
        j = (k - 10) / 2;
        if (k % 2 == 0) return (k == 20) ? 20 : j;
        if (k == 23) return 16'h0112;
        return (j % 2 == 0) ? j : j + 12;
    endfunction

    // R3: byte n at bits [8n+7:8n]; kind in byte 4, index in bytes 6 (high) and 7 (low)
    function automatic logic [127:0] gen_spare(input int run, input int k);
        logic [127:0] s;
        int li;
        for (int n = 0; n < 16; n++) s[8*n +: 8] = 8'(k * 3 + n + run * 40);
        li = gen_lidx(run, k);
        s[8*4 +: 8] = gen_kind(run, k);
        s[8*6 +: 8] = 8'(li >> 8);
        s[8*7 +: 8] = 8'(li);
        return s;
    endfunction

    task automatic send_rec(input int run, input int k);
        rec_valid = 1'b1;
        rec_bank  = BANK_W'(k / SEGS);
        rec_pseg  = PSEG_W'(k % SEGS);
        rec_spare = gen_spare(run, k);
        while (!rec_ready) @(negedge clk);
        @(negedge clk);
        rec_valid = 1'b0;
        chk(rec_ready == 1'b0, "R8 ready low after accept", int'(rec_ready), 0);
    endtask

    task automatic build_model(input int run, input int nb);
        int li;
        for (int i = 0; i < DEPTH; i++) mdl_v[i] = 0;
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < nb * SEGS; k++) begin
                li = gen_lidx(run, k);
                if (li < DEPTH && gen_kind(run, k) == ((p == 0) ? 8'h17 : 8'h13)) begin
                    mdl_v[li]    = 1;
                    mdl_bank[li] = k / SEGS;
                    mdl_pseg[li] = k % SEGS;
                end
            end
        end
    endtask

    task automatic lookup(input int idx);
        bit eh;
        lk_req = 1'b1;
        lk_idx = 16'(idx);
        @(negedge clk);
        lk_req = 1'b0;
        eh = (idx < DEPTH) ? mdl_v[idx] : 1'b0;
        chk(lk_ack == 1'b1, "R10 ack one cycle later", int'(lk_ack), 1);
        if (idx < DEPTH)
            chk(lk_hit == eh, "R4/R5 entry presence", int'(lk_hit), int'(eh));
        else
            chk(lk_hit == 1'b0, "R6 out-of-range lookup", int'(lk_hit), 0);
        if (eh) begin
            chk(int'(lk_bank) == mdl_bank[idx], "R4/R5 bank field", int'(lk_bank), mdl_bank[idx]);
            chk(int'(lk_pseg) == mdl_pseg[idx], "R4/R5 pseg field", int'(lk_pseg), mdl_pseg[idx]);
        end
    endtask

    task automatic run_build(input int run, input int nb, input int exp_cache, input bit exp_ovf);
        int lowc;
        num_banks = BANKC_W'(nb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lowc = 0;
        while (!rec_ready && lowc < 1000) begin
            lowc++;
            @(negedge clk);
        end
        chk(lowc == DEPTH, "R2 clear length", lowc, DEPTH);
        for (int k = 0; k < nb * SEGS; k++) send_rec(run, k);
        chk(done == 1'b0, "R7 no done after base pass", int'(done), 0);
        for (int k = 0; k < nb * SEGS; k++) send_rec(run, k);
        @(negedge clk);
        chk(done == 1'b1, "R9 done after override pass", int'(done), 1);
        chk(rec_ready == 1'b0, "R9 ready low when done", int'(rec_ready), 0);
        chk(int'(cache_segs) == exp_cache, "R11 cache count", int'(cache_segs), exp_cache);
        chk(cache_overflow == exp_ovf, "R11 overflow flag", int'(cache_overflow), int'(exp_ovf));
        build_model(run, nb);
        for (int i = 0; i < DEPTH + 4; i++) lookup(i);
        lookup(16'h0112);
        lookup(16'h0100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(done == 1'b0, "R1 done at reset", int'(done), 0);
        chk(rec_ready == 1'b0, "R1 ready at reset", int'(rec_ready), 0);
        chk(int'(cache_segs) == 0, "R1 cache count at reset", int'(cache_segs), 0);
        chk(cache_overflow == 1'b0, "R1 overflow at reset", int'(cache_overflow), 0);
        lk_req = 1'b1;
        lk_idx = 16'd3;
        @(negedge clk);
        lk_req = 1'b0;
        chk(lk_ack == 1'b0, "R1 no ack before done", int'(lk_ack), 0);
        chk(lk_hit == 1'b0, "R1 no hit before done", int'(lk_hit), 0);
        // two banks, mixed kinds, three cache segments
        run_build(0, 2, 3, 1'b0);
        // four banks, ten cache segments, collisions, clear of the earlier build
        run_build(1, 4, MAXC, 1'b1);
        // R11 overflow is cleared by a new start
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(cache_overflow == 1'b0, "R11 overflow cleared by start", int'(cache_overflow), 0);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule